// File: doc/BRIEF.md
# Paged MDIO management slave

This block is the PHY side of a two-wire management link. It oversamples the management clock and data lines with a faster system clock. It decodes Clause-22 style read and write frames that carry its own strapped 5-bit PHY address. It answers those frames from a small register file.

The 5-bit register address reaches only 32 locations. A page register, present at the same address on every page, picks which page the other addresses reach. Behind the pages sit three registers:

- an identifier;
- a clock-delay control register, whose two enables leave the block as plain outputs;
- a general control register, holding an interface-mode field and a self-clearing soft reset.

The block drives the data line only while it answers a read. The management clock may run at up to 12 MHz. The system clock must be at least four times faster than the management clock.

Top module: `mdio_paged_slave`

## Requirements
- R1: A frame is recognised only after 32 or more consecutive ones on the data line, sampled on rising management-clock edges. The frame continues with start bits 0 then 1, an opcode (binary 10 = read, 01 = write), the 5-bit PHY address, the 5-bit register address, two turnaround bits and 16 data bits. All fields are sent most significant bit first.
- R2: On a read, `mdio_oe` stays low through the first turnaround bit. It rises after the next falling clock edge, with `mdio_o` = 0 as the acknowledge. The 16 data bits follow, most significant first, each changed after a falling edge. `mdio_oe` is released after the falling edge that ends the last data bit. `mdio_oe` is never high at any other time.
- R3: A frame whose PHY address differs from `phy_addr` is ignored. A write to it changes no register. A read to it leaves the line undriven, so it reads back all ones with no acknowledge.
- R4: If the two bits after the preamble are not 0 then 1, the frame is dropped and preamble detection restarts from zero. Any write in that frame has no effect.
- R5: Register address 22 is the page register on every page. A write stores all 16 data bits, and a read returns them. After reset the page is 0.
- R6: On page 0, register address 2 reads 0x0141.
- R7: On page 2, register address 21 holds the transmit delay enable in bit 4 (output `tx_delay_en`) and the receive delay enable in bit 5 (output `rx_delay_en`). Its other bits read 0. Both enables reset to 1.
- R8: On page 18, register address 20 bits [2:0] hold the mode field, output on `mode`. The field resets to 3'b111. Writing 3'b000 selects the RGMII-to-copper mode.
- R9: Writing page 18 register 20 with bit 15 set raises `soft_rst` for exactly 16 system clocks. After that pulse both delay enables return to 1, while the page and mode keep their values. A later read shows bit 15 as 0.
- R10: Any other page and address pair reads as 0, and writes to it change nothing. This includes address 20 or 21 on the wrong page, where a bit-15 write starts no soft reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the management clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mdc | input | 1 | Management clock from the master |
| mdio_i | input | 1 | Management data line as seen at the pin |
| mdio_o | output | 1 | Data value driven while answering a read |
| mdio_oe | output | 1 | Drive enable for `mdio_o` |
| phy_addr | input | 5 | Strapped PHY address this block answers to |
| tx_delay_en | output | 1 | Transmit clock delay enable |
| rx_delay_en | output | 1 | Receive clock delay enable |
| mode | output | 3 | Interface mode field |
| soft_rst | output | 1 | Soft reset pulse |

## Verification
The hardest state to reach is the soft-reset window. Page, mode and delay state must be observed there, even though each frame takes about a thousand system clocks and the pulse is only 16 long. The bench therefore first clears the delay enables, then issues the paged write that sets bit 15. It measures the width of the `soft_rst` pulse from the outputs, and reads back page, mode and bit 15 in the frames that follow. Malformed start fields, foreign PHY addresses and pages that hide a register are reached by directed frames. A fixed-seed random sequence of paged reads and writes then runs against a bench model of the register file.

// File: rtl/mdio_paged_slave.sv
module mdio_paged_slave #(
  parameter logic [15:0] ID_VALUE    = 16'h0141,
  parameter int          SRST_CYCLES = 16,
  parameter bit          TXD_RST     = 1'b1,
  parameter bit          RXD_RST     = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mdc,
  input  logic       mdio_i,
  output logic       mdio_o,
  output logic       mdio_oe,
  input  logic [4:0] phy_addr,
  output logic       tx_delay_en,
  output logic       rx_delay_en,
  output logic [2:0] mode,
  output logic       soft_rst
);
  localparam int CW = $clog2(SRST_CYCLES + 1);
  localparam logic [4:0]  A_PAGE = 5'd22;
  localparam logic [4:0]  A_ID   = 5'd2;
  localparam logic [4:0]  A_DLY  = 5'd21;
  localparam logic [4:0]  A_GEN  = 5'd20;
  localparam logic [15:0] P_ID   = 16'd0;
  localparam logic [15:0] P_DLY  = 16'd2;
  localparam logic [15:0] P_GEN  = 16'd18;

  typedef enum logic [2:0] {S_PRE, S_ST1, S_HDR, S_RD, S_WR} st_t;

  st_t            st;
  logic [2:0]     mdc_sr;
  logic [1:0]     dio_sr;
  logic [5:0]     cnt;
  logic [14:0]    sh;
  logic [4:0]     ra;
  logic [15:0]    rdv;
  logic [15:0]    page;
  logic [15:0]    rmux;
  logic [CW-1:0]  srst_cnt;

  wire        rise    = mdc_sr[1] & ~mdc_sr[2];
  wire        fall    = ~mdc_sr[1] & mdc_sr[2];
  wire        din     = dio_sr[1];
  wire [11:0] hdr     = {sh[10:0], din};
  wire [15:0] wdata   = {sh[14:0], din};
  wire        hit     = (hdr[9:5] == phy_addr);
  wire        wr_fire = (st == S_WR) && rise && (cnt == 6'd17);

  assign soft_rst = (srst_cnt != '0);
  assign mdio_oe  = (st == S_RD) && (cnt >= 6'd2);
  assign mdio_o   = (st == S_RD) && (cnt >= 6'd3) ? rdv[4'(6'd18 - cnt)] : 1'b0;

  always_comb begin
    rmux = '0;
    if (hdr[4:0] == A_PAGE)                     rmux = page;
    else if (page == P_ID  && hdr[4:0] == A_ID)  rmux = ID_VALUE;
    else if (page == P_DLY && hdr[4:0] == A_DLY) rmux = {10'd0, rx_delay_en, tx_delay_en, 4'd0};
    else if (page == P_GEN && hdr[4:0] == A_GEN) rmux = {soft_rst, 12'd0, mode};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mdc_sr <= '0;
      dio_sr <= '1;
    end else begin
      mdc_sr <= {mdc_sr[1:0], mdc};
      dio_sr <= {dio_sr[0], mdio_i};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= S_PRE;
      cnt <= '0;
      sh  <= '0;
      ra  <= '0;
      rdv <= '0;
    end else begin
      case (st)
        S_PRE: if (rise) begin
          if (din)                cnt <= (cnt == 6'd32) ? cnt : cnt + 6'd1;
          else if (cnt == 6'd32)  st  <= S_ST1;
          else                    cnt <= '0;
        end
        S_ST1: if (rise) begin
          cnt <= '0;
          st  <= din ? S_HDR : S_PRE;
        end
        S_HDR: if (rise) begin
          sh  <= {sh[13:0], din};
          cnt <= cnt + 6'd1;
          if (cnt == 6'd11) begin
            cnt <= '0;
            ra  <= hdr[4:0];
            rdv <= rmux;
            if (hit && hdr[11:10] == 2'b10)      st <= S_RD;
            else if (hit && hdr[11:10] == 2'b01) st <= S_WR;
            else                                 st <= S_PRE;
          end
        end
        S_RD: if (fall) begin
          cnt <= cnt + 6'd1;
          if (cnt == 6'd18) begin
            cnt <= '0;
            st  <= S_PRE;
          end
        end
        S_WR: if (rise) begin
          sh  <= {sh[13:0], din};
          cnt <= cnt + 6'd1;
          if (cnt == 6'd17) begin
            cnt <= '0;
            st  <= S_PRE;
          end
        end
        default: st <= S_PRE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      page        <= '0;
      tx_delay_en <= TXD_RST;
      rx_delay_en <= RXD_RST;
      mode        <= 3'b111;
      srst_cnt    <= '0;
    end else begin
      if (soft_rst) begin
        srst_cnt <= srst_cnt - 1'b1;
        if (srst_cnt == CW'(1)) begin
          tx_delay_en <= TXD_RST;
          rx_delay_en <= RXD_RST;
        end
      end
      if (wr_fire) begin
        if (ra == A_PAGE) page <= wdata;
        else if (page == P_DLY && ra == A_DLY) begin
          tx_delay_en <= wdata[4];
          rx_delay_en <= wdata[5];
        end else if (page == P_GEN && ra == A_GEN) begin
          mode <= wdata[2:0];
          if (wdata[15]) srst_cnt <= CW'(SRST_CYCLES);
        end
      end
    end
  end
endmodule

// File: rtl/mdio_paged_slave_chk.sv
module mdio_paged_slave_chk #(
  parameter int SRST_CYCLES = 16,
  parameter bit TXD_RST     = 1'b1,
  parameter bit RXD_RST     = 1'b1
) (
  input logic       clk,
  input logic       rst_n,
  input logic       mdio_o,
  input logic       mdio_oe,
  input logic       tx_delay_en,
  input logic       rx_delay_en,
  input logic [2:0] mode,
  input logic       soft_rst
);
  int unsigned run_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_len <= 0;
    else        run_len <= soft_rst ? run_len + 1 : 0;
  end

  // R2: the first driven bit of a read is the acknowledge zero
  p_ack_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mdio_oe) |-> !mdio_o);

  // R9: pulse never outlasts its fixed length
  p_pulse_len_r9: assert property (@(posedge clk) disable iff (!rst_n)
    run_len <= 32'(SRST_CYCLES));

  // R9: delay enables are back at their defaults when the pulse ends
  p_dly_default_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(soft_rst) |-> (tx_delay_en == TXD_RST) && (rx_delay_en == RXD_RST));

  // R9: mode survives the soft reset
  p_mode_kept_r9: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst && $past(soft_rst) |-> $stable(mode));
endmodule

bind mdio_paged_slave mdio_paged_slave_chk #(
  .SRST_CYCLES(SRST_CYCLES), .TXD_RST(TXD_RST), .RXD_RST(RXD_RST)
) u_chk (
  .clk(clk), .rst_n(rst_n), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
  .tx_delay_en(tx_delay_en), .rx_delay_en(rx_delay_en), .mode(mode),
  .soft_rst(soft_rst)
);

// File: tb/sim_mdio_paged_slave.sv
module sim_mdio_paged_slave;
  logic clk = 1'b0, rst_n = 1'b0, mdc = 1'b0, m_oe = 1'b0, m_val = 1'b1;
  logic [4:0] strap = 5'd3;
  logic mdio_o, mdio_oe, tx, rx, srst;
  logic [2:0] mode;
  wire bus = mdio_oe ? mdio_o : (m_oe ? m_val : 1'b1);

  int runs = 0, fails = 0, clash = 0, srun = 0, last_w = 0;
  logic [15:0] mpage = 16'd0;
  logic mtx = 1'b1, mrx = 1'b1;
  logic [2:0] mmode = 3'b111;

  always #2 clk = ~clk;

  mdio_paged_slave u0 (
    .clk(clk), .rst_n(rst_n), .mdc(mdc), .mdio_i(bus), .mdio_o(mdio_o),
    .mdio_oe(mdio_oe), .phy_addr(strap), .tx_delay_en(tx), .rx_delay_en(rx),
    .mode(mode), .soft_rst(srst)
  );

  always @(negedge clk) begin
    if (mdio_oe && m_oe) clash++;
    if (rst_n) begin
      if (srst) srun++;
      else if (srun != 0) begin last_w = srun; srun = 0; end
    end
  end

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    runs++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  task automatic bit_cyc(input logic b, input logic drv, output logic s);
    m_oe = drv; m_val = b;
    repeat (8) @(negedge clk);
    s = bus; mdc = 1'b1;
    repeat (8) @(negedge clk);
    mdc = 1'b0;
  endtask

  task automatic frame(input logic [1:0] stb, input logic [1:0] op, input logic [4:0] phy,
                       input logic [4:0] ra, input logic [15:0] wd,
                       output logic [15:0] rd, output logic ta1, output logic ta2);
    logic s;
    logic [13:0] head = {stb, op, phy, ra};
    for (int i = 0; i < 32; i++) bit_cyc(1'b1, 1'b1, s);
    for (int i = 13; i >= 0; i--) bit_cyc(head[i], 1'b1, s);
    if (op == 2'b10) begin
      bit_cyc(1'b1, 1'b0, ta1);
      bit_cyc(1'b1, 1'b0, ta2);
      for (int i = 15; i >= 0; i--) begin bit_cyc(1'b1, 1'b0, s); rd[i] = s; end
    end else begin
      bit_cyc(1'b1, 1'b1, ta1);
      bit_cyc(1'b0, 1'b1, ta2);
      for (int i = 15; i >= 0; i--) bit_cyc(wd[i], 1'b1, s);
      rd = '0;
    end
    bit_cyc(1'b1, 1'b0, s);
  endtask

  task automatic wr(input logic [4:0] phy, input logic [4:0] ra, input logic [15:0] d);
    logic [15:0] r; logic a, b;
    frame(2'b01, 2'b01, phy, ra, d, r, a, b);
    if (phy == strap) begin
      if (ra == 5'd22) mpage = d;
      else if (mpage == 16'd2 && ra == 5'd21) begin mtx = d[4]; mrx = d[5]; end
      else if (mpage == 16'd18 && ra == 5'd20) begin
        mmode = d[2:0];
        if (d[15]) begin mtx = 1'b1; mrx = 1'b1; end
      end
    end
    repeat (24) @(negedge clk);
  endtask

  function automatic logic [15:0] exp_rd(input logic [4:0] ra);
    if (ra == 5'd22) return mpage;
    if (mpage == 16'd0 && ra == 5'd2) return 16'h0141;
    if (mpage == 16'd2 && ra == 5'd21) return {10'd0, mrx, mtx, 4'd0};
    if (mpage == 16'd18 && ra == 5'd20) return {13'd0, mmode};
    return 16'd0;
  endfunction

  task automatic rd_chk(input string tag, input logic [4:0] phy, input logic [4:0] ra);
    logic [15:0] r; logic a, b;
    frame(2'b01, 2'b10, phy, ra, 16'd0, r, a, b);
    if (phy == strap) begin
      chk({tag, " read data"}, r, exp_rd(ra));
      chk("R2 ta1 released", a, 1'b1);
      chk("R2 ack zero", b, 1'b0);
    end else begin
      chk("R3 foreign read undriven", {b, r}, 17'h1ffff);
    end
    chk("R2 released after read", mdio_oe, 1'b0);
  endtask

  task automatic out_chk(input string tag);
    chk({tag, " tx_delay_en"}, tx, mtx);
    chk({tag, " rx_delay_en"}, rx, mrx);
    chk({tag, " mode"}, mode, mmode);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    runs++; fails++;
    $display("FAIL R1 watchdog got timeout exp completion");
    $display("[TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end

  initial begin
    logic [15:0] r; logic a, b;
    void'($urandom(32'd4242));
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R2 reset oe", mdio_oe, 1'b0);
    chk("R9 reset soft_rst", srst, 1'b0);
    out_chk("R7 R8 reset");

    rd_chk("R6 id", strap, 5'd2);
    rd_chk("R5 page reset", strap, 5'd22);
    wr(strap, 5'd22, 16'd2);
    rd_chk("R5 page sel", strap, 5'd22);
    wr(strap, 5'd21, 16'h0000);
    out_chk("R7 clear");
    wr(strap, 5'd21, 16'hFFEF);
    out_chk("R7 rx only");
    rd_chk("R7 readback", strap, 5'd21);
    rd_chk("R10 id hidden on page 2", strap, 5'd2);
    last_w = 0;
    wr(strap, 5'd20, 16'h8000);
    chk("R10 no soft reset on page 2", last_w, 0);

    wr(strap, 5'd22, 16'd18);
    rd_chk("R8 mode reset", strap, 5'd20);
    wr(strap, 5'd20, 16'h0000);
    out_chk("R8 rgmii mode");
    wr(strap, 5'd22, 16'd2);
    wr(strap, 5'd21, 16'h0000);
    wr(strap, 5'd22, 16'd18);
    last_w = 0;
    wr(strap, 5'd20, 16'h8005);
    chk("R9 pulse width", last_w, 16);
    out_chk("R9 after soft reset");
    rd_chk("R9 bit15 clear", strap, 5'd20);
    rd_chk("R9 page kept", strap, 5'd22);

    wr(strap ^ 5'd1, 5'd22, 16'd0);
    rd_chk("R3 foreign write ignored", strap, 5'd22);
    rd_chk("R3", strap ^ 5'd1, 5'd20);

    frame(2'b00, 2'b01, strap, 5'd22, 16'd0, r, a, b);
    repeat (24) @(negedge clk);
    rd_chk("R4 bad start ignored", strap, 5'd22);
    frame(2'b11, 2'b01, strap, 5'd20, 16'h8001, r, a, b);
    repeat (24) @(negedge clk);
    out_chk("R4 bad start ignored");
    rd_chk("R1 frame after bad start", strap, 5'd20);

    wr(strap, 5'd5, 16'hABCD);
    rd_chk("R10 unimplemented", strap, 5'd5);

    for (int i = 0; i < 36; i++) begin
      logic [4:0] phy = ($urandom % 6 == 0) ? (strap ^ 5'd4) : strap;
      logic [4:0] ra;
      logic [15:0] d = 16'($urandom);
      case ($urandom % 5)
        0: ra = 5'd22;
        1: ra = 5'd20;
        2: ra = 5'd21;
        3: ra = 5'd2;
        default: ra = 5'($urandom);
      endcase
      if (ra == 5'd22) begin
        case ($urandom % 4)
          0: d = 16'd0;
          1: d = 16'd2;
          2: d = 16'd18;
          default: d = 16'($urandom % 32);
        endcase
      end
      if ($urandom % 2 == 0) wr(phy, ra, d);
      else rd_chk("R1 random", phy, ra);
      out_chk("R1 random outputs");
    end

    chk("R2 no contention", clash, 0);
    $display("[TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end
endmodule